// File: doc/BRIEF.md
# Two-Level Interrupt Routing Controller

This block gathers a set of level-sensitive, active-high event inputs and steers each of them to one host interrupt output through two many-to-one stages. In the first stage every event is assigned to one of ten channels. In the second stage every channel is assigned to one of ten host outputs. The channel number is also the priority: a lower channel number wins. Host 0 serves processor core 0 and host 1 serves core 1. Hosts 2 to 9 are the eight interrupt lines to the main CPU.

Software uses a simple synchronous 32-bit register bus to program both maps, set the event enables and clear latched status. Each event latches into a status bit while its input is high. It stays pending until software writes 1 to its clear bit. Each host exposes an index word that names its highest-priority pending event, or flags that nothing is pending. The inputs have no polarity or trigger-type options: every input is a high-active level. All routing and priority logic is combinational from the stored maps, the status bits and the live inputs.

Register word addresses:

| Address | Contents |
|---|---|
| 0x00+k | Enables |
| 0x04+k | Status (read) |
| 0x08+k | Clear (write) |
| 0x0C+k | Channel-to-host map |
| 0x10+k | Event-to-channel map |
| 0x30+h | Index word of host h |

Top module: `irq_router`

## Requirements
- R1: After reset all enables, status bits and map fields are 0, host_irq is 0, and every index word reads 0x8000_0000.
- R2: The field of event e in the event-to-channel map sits at word 0x10+e/8, bits [4*(e%8)+3:4*(e%8)]. The field of channel c in the channel-to-host map sits at word 0x0C+c/8, bits [4*(c%8)+3:4*(c%8)]. Written fields read back unchanged. Bits of channel-map words that belong to no channel read 0. bus_rdata changes only in the cycle after a read strobe.
- R3: host_irq[h] is high exactly while some pending, enabled event is routed through its channel to host h.
- R4: Enable bit e sits at word 0x00+e/32, bit e%32. An event whose enable bit is 0 drives no host output and no index word, even while it is pending.
- R5: Status bit e sits at word 0x04+e/32, bit e%32. It is set on any clock edge where input e is high, whatever the enable bit is. It stays set after the input falls, and the event remains pending.
- R6: Writing 1 to bit e%32 of clear word 0x08+e/32 clears status bit e. A 0 written to a clear bit has no effect. If the input is still high, the status bit stays set.
- R7: When pending events reach one host through several channels, the index names the event on the lowest-numbered channel.
- R8: When several pending events share the winning channel, the index names the lowest-numbered event.
- R9: A host with nothing pending reads its index word as bit 31 set and all other bits 0.
- R10: An event-map value of 10 or more routes the event to no channel. A channel-map value of 10 or more routes the channel to no host.
- R11: When a host has a pending event, its index word holds the event number in bits 9:0, and bits 31:10 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 64 | Level-sensitive, active-high event inputs |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe; data appears on the next cycle |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| host_irq | output | 10 | Host interrupt outputs |

## Verification
The bench builds the block with its default parameters: 64 events, 10 channels and 10 hosts. With these values the upper enable and status word and the last event-map words are in reach, as are channels 8 and 9 in the second channel-map word and the highest host lines. The 4-bit map fields can also hold the unused values 10 to 15, so the bench can drive the invalid-route case directly.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned FLD_W       = 4;
  localparam int unsigned FLD_PER_WD  = DATA_W / FLD_W;
  localparam int unsigned EVT_IDX_W   = 10;
  localparam int unsigned NONE_BIT    = 31;

  localparam int unsigned A_EN   = 'h00;
  localparam int unsigned A_STAT = 'h04;
  localparam int unsigned A_CLR  = 'h08;
  localparam int unsigned A_CHH  = 'h0C;
  localparam int unsigned A_ECH  = 'h10;
  localparam int unsigned A_IDX  = 'h30;
endpackage

// File: rtl/irq_rt_regs.sv
module irq_rt_regs
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 64,
  parameter int unsigned NUM_CH   = 10,
  parameter int unsigned NUM_HOST = 10
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_EVT-1:0]                  evt_in,
  input  logic                                bus_wr_en,
  input  logic                                bus_rd_en,
  input  logic [ADDR_W-1:0]                   bus_addr,
  input  logic [DATA_W-1:0]                   bus_wdata,
  output logic [DATA_W-1:0]                   bus_rdata,
  input  logic [NUM_HOST-1:0][DATA_W-1:0]     host_word,
  output logic [NUM_EVT-1:0]                  en_q,
  output logic [NUM_EVT-1:0]                  status_q,
  output logic [NUM_EVT-1:0][FLD_W-1:0]       ech_q,
  output logic [NUM_CH-1:0][FLD_W-1:0]        chh_q
);
  logic [NUM_EVT-1:0]            en_d, status_d;
  logic [NUM_EVT-1:0][FLD_W-1:0] ech_d;
  logic [NUM_CH-1:0][FLD_W-1:0]  chh_d;
  logic [DATA_W-1:0]             rd_mux;

  always_comb begin
    en_d     = en_q;
    status_d = status_q;
    ech_d    = ech_q;
    chh_d    = chh_q;
    for (int unsigned e = 0; e < NUM_EVT; e++) begin
      if (bus_wr_en && bus_addr == ADDR_W'(A_EN + e / DATA_W))
        en_d[e] = bus_wdata[e % DATA_W];
      if (bus_wr_en && bus_addr == ADDR_W'(A_CLR + e / DATA_W) && bus_wdata[e % DATA_W])
        status_d[e] = 1'b0;
      if (evt_in[e])
        status_d[e] = 1'b1;
      if (bus_wr_en && bus_addr == ADDR_W'(A_ECH + e / FLD_PER_WD))
        ech_d[e] = bus_wdata[(e % FLD_PER_WD) * FLD_W +: FLD_W];
    end
    for (int unsigned c = 0; c < NUM_CH; c++) begin
      if (bus_wr_en && bus_addr == ADDR_W'(A_CHH + c / FLD_PER_WD))
        chh_d[c] = bus_wdata[(c % FLD_PER_WD) * FLD_W +: FLD_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int unsigned e = 0; e < NUM_EVT; e++) begin
      if (bus_addr == ADDR_W'(A_EN + e / DATA_W))
        rd_mux[e % DATA_W] = en_q[e];
      if (bus_addr == ADDR_W'(A_STAT + e / DATA_W))
        rd_mux[e % DATA_W] = status_q[e];
      if (bus_addr == ADDR_W'(A_ECH + e / FLD_PER_WD))
        rd_mux[(e % FLD_PER_WD) * FLD_W +: FLD_W] = ech_q[e];
    end
    for (int unsigned c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(A_CHH + c / FLD_PER_WD))
        rd_mux[(c % FLD_PER_WD) * FLD_W +: FLD_W] = chh_q[c];
    end
    for (int unsigned h = 0; h < NUM_HOST; h++) begin
      if (bus_addr == ADDR_W'(A_IDX + h))
        rd_mux = host_word[h];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      status_q <= '0;
      ech_q    <= '0;
      chh_q    <= '0;
    end else begin
      en_q     <= en_d;
      status_q <= status_d;
      ech_q    <= ech_d;
      chh_q    <= chh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_rt_chan_sel.sv
module irq_rt_chan_sel
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_EVT = 64,
  parameter int unsigned NUM_CH  = 10
) (
  input  logic [NUM_EVT-1:0]                act,
  input  logic [NUM_EVT-1:0][FLD_W-1:0]     ech_q,
  output logic [NUM_CH-1:0]                 ch_v,
  output logic [NUM_CH-1:0][EVT_IDX_W-1:0]  ch_evt
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      ch_v[c]   = 1'b0;
      ch_evt[c] = '0;
      for (int e = NUM_EVT - 1; e >= 0; e--) begin
        if (act[e] && ech_q[e] == FLD_W'(c)) begin
          ch_v[c]   = 1'b1;
          ch_evt[c] = EVT_IDX_W'(e);
        end
      end
    end
  end
endmodule

// File: rtl/irq_rt_host_sel.sv
module irq_rt_host_sel
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_CH   = 10,
  parameter int unsigned NUM_HOST = 10
) (
  input  logic [NUM_CH-1:0]                 ch_v,
  input  logic [NUM_CH-1:0][EVT_IDX_W-1:0]  ch_evt,
  input  logic [NUM_CH-1:0][FLD_W-1:0]      chh_q,
  output logic [NUM_HOST-1:0]               host_irq,
  output logic [NUM_HOST-1:0][DATA_W-1:0]   host_word
);
  for (genvar h = 0; h < NUM_HOST; h++) begin : g_host
    logic                 hit;
    logic [EVT_IDX_W-1:0] win;
    always_comb begin
      hit = 1'b0;
      win = '0;
      for (int c = NUM_CH - 1; c >= 0; c--) begin
        if (ch_v[c] && chh_q[c] == FLD_W'(h)) begin
          hit = 1'b1;
          win = ch_evt[c];
        end
      end
    end
    assign host_irq[h]  = hit;
    assign host_word[h] = hit ? DATA_W'(win) : (DATA_W'(1) << NONE_BIT);
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 64,
  parameter int unsigned NUM_CH   = 10,
  parameter int unsigned NUM_HOST = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EVT-1:0]  evt_in,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_HOST-1:0] host_irq
);
  logic [NUM_EVT-1:0]                en_q, status_q, act;
  logic [NUM_EVT-1:0][FLD_W-1:0]     ech_q;
  logic [NUM_CH-1:0][FLD_W-1:0]      chh_q;
  logic [NUM_CH-1:0]                 ch_v;
  logic [NUM_CH-1:0][EVT_IDX_W-1:0]  ch_evt;
  logic [NUM_HOST-1:0][DATA_W-1:0]   host_word;

  irq_rt_regs #(.NUM_EVT(NUM_EVT), .NUM_CH(NUM_CH), .NUM_HOST(NUM_HOST)) u_regs (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_word(host_word),
    .en_q(en_q), .status_q(status_q), .ech_q(ech_q), .chh_q(chh_q)
  );

  assign act = (evt_in | status_q) & en_q;

  irq_rt_chan_sel #(.NUM_EVT(NUM_EVT), .NUM_CH(NUM_CH)) u_chan (
    .act(act), .ech_q(ech_q), .ch_v(ch_v), .ch_evt(ch_evt)
  );

  irq_rt_host_sel #(.NUM_CH(NUM_CH), .NUM_HOST(NUM_HOST)) u_host (
    .ch_v(ch_v), .ch_evt(ch_evt), .chh_q(chh_q),
    .host_irq(host_irq), .host_word(host_word)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 64,
  parameter int unsigned NUM_HOST = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_EVT-1:0]  evt_in,
  input logic                bus_wr_en,
  input logic                bus_rd_en,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_HOST-1:0] host_irq,
  input logic [NUM_EVT-1:0]  en_q,
  input logic [NUM_EVT-1:0]  status_q
);
  logic [NUM_EVT-1:0] clr_v, keep_v;
  always_comb begin
    for (int unsigned e = 0; e < NUM_EVT; e++)
      clr_v[e] = bus_wr_en && bus_addr == ADDR_W'(A_CLR + e / DATA_W) && bus_wdata[e % DATA_W];
  end
  assign keep_v = status_q & ~clr_v;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (host_irq == '0)); // R4
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq != '0) |-> (((evt_in | status_q) & en_q) != '0)); // R3
  AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_v != '0) |=> ((status_q & $past(keep_v)) == $past(keep_v))); // R5
  AST_INPUT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0) |=> ((status_q & $past(evt_in)) == $past(evt_in))); // R5
  AST_CLEAR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_v & ~evt_in) != '0) |=> ((status_q & $past(clr_v & ~evt_in)) == '0)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> $stable(bus_rdata)); // R2
endmodule

bind irq_router irq_router_chk #(.NUM_EVT(NUM_EVT), .NUM_HOST(NUM_HOST)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_wr_en(bus_wr_en),
  .bus_rd_en(bus_rd_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .host_irq(host_irq), .en_q(en_q), .status_q(status_q)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NONE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt_in = '0;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [9:0]  host_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [31:0] ech_sh [8];
  logic [31:0] chh_sh [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .host_irq(host_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_ech(int e, int c);
    ech_sh[e/8][(e%8)*4 +: 4] = 4'(c);
    wr(8'(8'h10 + e/8), ech_sh[e/8]);
  endtask

  task automatic set_chh(int c, int h);
    chh_sh[c/8][(c%8)*4 +: 4] = 4'(h);
    wr(8'(8'h0C + c/8), chh_sh[c/8]);
  endtask

  task automatic clean();
    @(negedge clk);
    evt_in = '0;
    wr(8'h00, 32'h0); wr(8'h01, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h09, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 host_irq", 32'(host_irq), 32'h0);
    rd(8'h00, d); chk("R1 enable", d, 32'h0);
    rd(8'h05, d); chk("R1 status", d, 32'h0);
    rd(8'h17, d); chk("R1 event map", d, 32'h0);
    rd(8'h0C, d); chk("R1 channel map", d, 32'h0);
    rd(8'h39, d); chk("R1 index host9", d, NONE);
  endtask

  task automatic t_maps();
    logic [31:0] d;
    ech_sh[3] = 32'h1234_5678; wr(8'h13, ech_sh[3]);
    rd(8'h13, d); chk("R2 event map readback", d, 32'h1234_5678);
    ech_sh[3] = 32'h0; wr(8'h13, 32'h0);
    wr(8'h0D, 32'hFFFF_FF98);
    rd(8'h0D, d); chk("R2 channel map unused bits", d, 32'h0000_0098);
    wr(8'h0D, 32'h0); chh_sh[1] = 32'h0;
  endtask

  task automatic t_route_basic();
    logic [31:0] d;
    set_ech(5, 3); set_chh(3, 7);
    wr(8'h00, 32'h0000_0020);
    @(negedge clk); evt_in[5] = 1'b1;
    #1 chk("R3 host7 raised", 32'(host_irq), 32'h80);
    rd(8'h37, d); chk("R11 index host7", d, 32'd5);
    @(negedge clk); evt_in[5] = 1'b0;
    #1 chk("R5 pending after input falls", 32'(host_irq), 32'h80);
    wr(8'h08, 32'h0000_0020);
    chk("R6 cleared", 32'(host_irq), 32'h0);
    rd(8'h37, d); chk("R9 idle index", d, NONE);
    clean();
  endtask

  task automatic t_enable_gate();
    logic [31:0] d;
    set_ech(40, 1); set_chh(1, 2);
    @(negedge clk); evt_in[40] = 1'b1;
    @(negedge clk);
    chk("R4 disabled no irq", 32'(host_irq), 32'h0);
    rd(8'h32, d); chk("R4 disabled no index", d, NONE);
    rd(8'h05, d); chk("R5 status while disabled", d, 32'h0000_0100);
    wr(8'h01, 32'h0000_0100);
    chk("R4 enabled irq", 32'(host_irq), 32'h004);
    wr(8'h09, 32'h0000_0100);
    rd(8'h05, d); chk("R6 clear with input high", d, 32'h0000_0100);
    @(negedge clk); evt_in[40] = 1'b0;
    wr(8'h09, 32'h0000_0000);
    rd(8'h05, d); chk("R6 zero clear no effect", d, 32'h0000_0100);
    wr(8'h09, 32'h0000_0100);
    rd(8'h05, d); chk("R6 clear after input low", d, 32'h0);
    clean();
  endtask

  task automatic t_chan_prio();
    logic [31:0] d;
    set_ech(10, 6); set_ech(20, 2); set_chh(6, 4); set_chh(2, 4);
    wr(8'h00, 32'h0010_0400);
    @(negedge clk); evt_in[10] = 1'b1; evt_in[20] = 1'b1;
    rd(8'h34, d); chk("R7 lower channel wins", d, 32'd20);
    @(negedge clk); evt_in[20] = 1'b0;
    wr(8'h08, 32'h0010_0000);
    rd(8'h34, d); chk("R7 next channel", d, 32'd10);
    chk("R3 host4 only", 32'(host_irq), 32'h010);
    clean();
    set_chh(6, 0); set_chh(2, 0);
  endtask

  task automatic t_evt_prio();
    logic [31:0] d;
    set_ech(50, 5); set_ech(33, 5); set_chh(5, 9);
    wr(8'h01, 32'h0004_0002);
    @(negedge clk); evt_in[50] = 1'b1; evt_in[33] = 1'b1;
    rd(8'h39, d); chk("R8 lowest event in channel", d, 32'd33);
    chk("R3 host9", 32'(host_irq), 32'h200);
    clean();
    set_ech(50, 0); set_ech(33, 0);
  endtask

  task automatic t_out_of_range();
    logic [31:0] d;
    set_ech(7, 12);
    wr(8'h00, 32'h0000_0080);
    @(negedge clk); evt_in[7] = 1'b1;
    #1 chk("R10 bad channel field", 32'(host_irq), 32'h0);
    rd(8'h30, d); chk("R10 host0 idle", d, NONE);
    set_ech(7, 4); set_chh(4, 11);
    chk("R10 bad host field", 32'(host_irq), 32'h0);
    set_chh(4, 1);
    chk("R3 host1 after fix", 32'(host_irq), 32'h002);
    clean();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) ech_sh[i] = '0;
    for (int i = 0; i < 2; i++) chh_sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_maps();
    t_route_basic();
    t_enable_gate();
    t_chan_prio();
    t_evt_prio();
    t_out_of_range();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule